// File: doc/BRIEF.md
# Unified Code/Data Memory Decoder

This block sits between an 8-bit microcontroller core and its memory targets. Every cycle it takes the core's 16-bit address and its three strobes: instruction fetch, data read and data write. It decides which target the access is for. Four targets are on chip: a main RAM port, a scratch RAM port, a register window port and an external bus. The external bus keeps program strobes and data strobes apart. The main RAM is the only target that serves both code and data. A fetch and a data read in the low 8 KB reach the same port at the same address, so a byte written as data can later be executed.

The decoder drives the enables and write strobes for these targets. It passes the address and write data to all of them. One cycle after a read it returns the chosen target's data to the core. To pick that data it uses the target it registered on the read cycle. A fetch and a data read in the same cycle break the core's protocol. The decoder then gives the fetch priority and raises an error flag. A write that arrives together with a fetch or with a data read is dropped.

Top module: `cdm_router`

## Requirements
- R1: A fetch or a data read with an address in 0x0000–0x1FFF asserts `main_en` with `main_we` low, and no other target enable.
- R2: A data write in 0x0000–0x1FFF asserts `main_en` and `main_we`. A later fetch at the same address returns the byte that was written.
- R3: A data read or data write in 0xE000–0xE1FF asserts `scr_en`, and the write also asserts `scr_we`. A read returns the stored byte.
- R4: A fetch at 0x2000 or above, including 0xE000–0xE1FF, asserts only `xp_rd`. `scr_en` is never asserted during a fetch, and the returned byte comes from `x_rdata`.
- R5: A data read or data write in 0xE200–0xFFFF asserts `csr_sel`, and the write also asserts `csr_we`.
- R6: A data read in 0x2000–0xDFFF asserts `xd_rd` and a data write there asserts `xd_wr`. A data access never asserts `xp_rd`.
- R7: When fetch and data read are high together, `dec_err` is 1 and the access is handled as a fetch. No data-only target (`scr_en`, `csr_sel`, `xd_rd`) is enabled.
- R8: A data write that comes with a fetch or with a data read writes nothing: `main_we`, `scr_we`, `csr_we` and `xd_wr` all stay 0. The stored byte is unchanged when read back.
- R9: `cpu_rdata` in the cycle after a read equals the selected target's read data. It is 0 in the cycle after a cycle with no read.
- R10: In any cycle at most one of main, scratch, register window, external program and external data is enabled.
- R11: While `rst_n` is low and no strobe is high, every enable and strobe output is 0 and `cpu_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Core address |
| cpu_fetch | input | 1 | Instruction fetch strobe |
| cpu_rd | input | 1 | Data read strobe |
| cpu_wr | input | 1 | Data write strobe |
| cpu_wdata | input | 8 | Core write data |
| cpu_rdata | output | 8 | Read data returned one cycle after the read |
| dec_err | output | 1 | Fetch and data read in the same cycle |
| mem_addr | output | 16 | Address passed to every target |
| mem_wdata | output | 8 | Write data passed to every target |
| main_en | output | 1 | Main RAM enable |
| main_we | output | 1 | Main RAM write |
| main_rdata | input | 8 | Main RAM read data (one-cycle latency) |
| scr_en | output | 1 | Scratch RAM enable |
| scr_we | output | 1 | Scratch RAM write |
| scr_rdata | input | 8 | Scratch RAM read data |
| csr_sel | output | 1 | Register window select |
| csr_we | output | 1 | Register window write |
| csr_rdata | input | 8 | Register window read data |
| xp_rd | output | 1 | External program read strobe |
| xd_rd | output | 1 | External data read strobe |
| xd_wr | output | 1 | External data write strobe |
| x_rdata | input | 8 | External bus read data |

## Verification
Two functions can land in the same cycle: the fetch path and a data strobe. One case is a fetch with a data read, the protocol error. The other is a fetch or data read with a data write. The bench drives each pair in two places: inside the unified RAM and inside the data-only windows. It then checks three things. The fetch must win, the error flag must follow the read collision only, and no write strobe may rise. A read of the same location afterwards must show the stored byte unchanged, which proves the dropped write reached nothing.

// File: rtl/cdm_pkg.sv
package cdm_pkg;
  typedef enum logic [2:0] {
    TGT_NONE  = 3'd0,
    TGT_MAIN  = 3'd1,
    TGT_SCR   = 3'd2,
    TGT_CSR   = 3'd3,
    TGT_XPROG = 3'd4,
    TGT_XDATA = 3'd5
  } tgt_e;
endpackage

// File: rtl/cdm_region_decode.sv
module cdm_region_decode
  import cdm_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned MAIN_TOP = 'h2000,
  parameter int unsigned SCR_BASE = 'hE000,
  parameter int unsigned SCR_TOP  = 'hE200
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              fetch,
  input  logic              rd,
  input  logic              wr,
  output tgt_e              tgt,
  output logic              is_read,
  output logic              wr_ok,
  output logic              conflict
);
  localparam logic [ADDR_W-1:0] MAIN_LIM = ADDR_W'(MAIN_TOP);
  localparam logic [ADDR_W-1:0] SCR_LO   = ADDR_W'(SCR_BASE);
  localparam logic [ADDR_W-1:0] SCR_HI   = ADDR_W'(SCR_TOP);

  // Fetch path: unified RAM low, everything else goes to the off-chip program space.
  function automatic tgt_e code_target(input logic [ADDR_W-1:0] a);
    return (a < MAIN_LIM) ? TGT_MAIN : TGT_XPROG;
  endfunction

  // Data path: unified RAM, off-chip data, scratch window, register window.
  function automatic tgt_e data_target(input logic [ADDR_W-1:0] a);
    if (a < MAIN_LIM)    return TGT_MAIN;
    else if (a < SCR_LO) return TGT_XDATA;
    else if (a < SCR_HI) return TGT_SCR;
    else                 return TGT_CSR;
  endfunction

  always_comb begin
    conflict = fetch & rd;
    is_read  = fetch | rd;
    wr_ok    = wr & ~fetch & ~rd;
    if (fetch)         tgt = code_target(addr);
    else if (rd || wr) tgt = data_target(addr);
    else               tgt = TGT_NONE;
  end
endmodule

// File: rtl/cdm_strobe_route.sv
module cdm_strobe_route
  import cdm_pkg::*;
(
  input  tgt_e tgt,
  input  logic is_read,
  input  logic wr_ok,
  output logic main_en,
  output logic main_we,
  output logic scr_en,
  output logic scr_we,
  output logic csr_sel,
  output logic csr_we,
  output logic xp_rd,
  output logic xd_rd,
  output logic xd_wr
);
  always_comb begin
    main_en = (tgt == TGT_MAIN);
    main_we = main_en & wr_ok;
    scr_en  = (tgt == TGT_SCR);
    scr_we  = scr_en & wr_ok;
    csr_sel = (tgt == TGT_CSR);
    csr_we  = csr_sel & wr_ok;
    xp_rd   = (tgt == TGT_XPROG);
    xd_rd   = (tgt == TGT_XDATA) & is_read;
    xd_wr   = (tgt == TGT_XDATA) & wr_ok;
  end
endmodule

// File: rtl/cdm_rdata_mux.sv
module cdm_rdata_mux
  import cdm_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tgt_e              tgt,
  input  logic              is_read,
  input  logic [DATA_W-1:0] main_rdata,
  input  logic [DATA_W-1:0] scr_rdata,
  input  logic [DATA_W-1:0] csr_rdata,
  input  logic [DATA_W-1:0] x_rdata,
  output tgt_e              sel_q,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n)       sel_q <= TGT_NONE;
    else if (is_read) sel_q <= tgt;
    else              sel_q <= TGT_NONE;
  end

  always_comb begin
    unique case (sel_q)
      TGT_MAIN:               rdata = main_rdata;
      TGT_SCR:                rdata = scr_rdata;
      TGT_CSR:                rdata = csr_rdata;
      TGT_XPROG, TGT_XDATA:   rdata = x_rdata;
      default:                rdata = '0;
    endcase
  end
endmodule

// File: rtl/cdm_router.sv
module cdm_router
  import cdm_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned MAIN_TOP = 'h2000,
  parameter int unsigned SCR_BASE = 'hE000,
  parameter int unsigned SCR_TOP  = 'hE200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_fetch,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              dec_err,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              main_en,
  output logic              main_we,
  input  logic [DATA_W-1:0] main_rdata,
  output logic              scr_en,
  output logic              scr_we,
  input  logic [DATA_W-1:0] scr_rdata,
  output logic              csr_sel,
  output logic              csr_we,
  input  logic [DATA_W-1:0] csr_rdata,
  output logic              xp_rd,
  output logic              xd_rd,
  output logic              xd_wr,
  input  logic [DATA_W-1:0] x_rdata
);
  tgt_e tgt_now;
  tgt_e tgt_held;
  logic rd_launch;
  logic wr_launch;
  logic strobe_clash;

  cdm_region_decode #(
    .ADDR_W(ADDR_W), .MAIN_TOP(MAIN_TOP), .SCR_BASE(SCR_BASE), .SCR_TOP(SCR_TOP)
  ) u_dec (
    .addr(cpu_addr), .fetch(cpu_fetch), .rd(cpu_rd), .wr(cpu_wr),
    .tgt(tgt_now), .is_read(rd_launch), .wr_ok(wr_launch), .conflict(strobe_clash)
  );

  cdm_strobe_route u_route (
    .tgt(tgt_now), .is_read(rd_launch), .wr_ok(wr_launch),
    .main_en(main_en), .main_we(main_we), .scr_en(scr_en), .scr_we(scr_we),
    .csr_sel(csr_sel), .csr_we(csr_we), .xp_rd(xp_rd), .xd_rd(xd_rd), .xd_wr(xd_wr)
  );

  cdm_rdata_mux #(.DATA_W(DATA_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .tgt(tgt_now), .is_read(rd_launch),
    .main_rdata(main_rdata), .scr_rdata(scr_rdata), .csr_rdata(csr_rdata),
    .x_rdata(x_rdata), .sel_q(tgt_held), .rdata(cpu_rdata)
  );

  assign dec_err   = strobe_clash;
  assign mem_addr  = cpu_addr;
  assign mem_wdata = cpu_wdata;
endmodule

// File: rtl/cdm_checker.sv
module cdm_checker #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned MAIN_TOP = 'h2000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_fetch,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              dec_err,
  input logic              main_en,
  input logic              main_we,
  input logic [DATA_W-1:0] main_rdata,
  input logic              scr_en,
  input logic              scr_we,
  input logic [DATA_W-1:0] scr_rdata,
  input logic              csr_sel,
  input logic              csr_we,
  input logic [DATA_W-1:0] csr_rdata,
  input logic              xp_rd,
  input logic              xd_rd,
  input logic              xd_wr,
  input logic [DATA_W-1:0] x_rdata
);
  localparam logic [ADDR_W-1:0] LOW_LIM = ADDR_W'(MAIN_TOP);

  a_r1_unified_read: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_fetch || cpu_rd) && cpu_addr < LOW_LIM) |-> (main_en && !main_we));

  a_r4_fetch_not_scratch: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_fetch |-> !scr_en);

  a_r6_harvard_split: assert property (@(posedge clk) disable iff (!rst_n)
    xp_rd |-> (!xd_rd && !xd_wr));

  a_r7_fetch_wins: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |-> (!scr_en && !csr_sel && !xd_rd && (main_en || xp_rd)));

  a_r8_no_write_on_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_fetch || cpu_rd) |-> !(main_we || scr_we || csr_we || xd_wr));

  a_r9_main_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (main_en && !main_we) |=> (cpu_rdata == main_rdata));

  a_r9_scr_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (scr_en && !scr_we) |=> (cpu_rdata == scr_rdata));

  a_r9_csr_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_sel && !csr_we) |=> (cpu_rdata == csr_rdata));

  a_r9_ext_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (xp_rd || xd_rd) |=> (cpu_rdata == x_rdata));

  a_r10_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({main_en, scr_en, csr_sel, xp_rd, (xd_rd || xd_wr)}));
endmodule

bind cdm_router cdm_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAIN_TOP(MAIN_TOP)
) u_chk (.*);

// File: tb/sim_cdm_router.sv
`timescale 1ns/1ps
module sim_cdm_router;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        cpu_fetch, cpu_rd, cpu_wr;
  logic [7:0]  cpu_wdata, cpu_rdata;
  logic        dec_err;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        main_en, main_we, scr_en, scr_we, csr_sel, csr_we;
  logic        xp_rd, xd_rd, xd_wr;
  logic [7:0]  main_rdata, scr_rdata, csr_rdata, x_rdata;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  cdm_router u0 (.*);

  // Target models, each with one cycle of read latency.
  logic [7:0] main_m [int];
  logic [7:0] scr_m  [int];
  logic [7:0] csr_m  [int];
  logic [7:0] xd_m   [int];

  function automatic logic [7:0] csr_dflt(input logic [15:0] a);
    return a[7:0] ^ 8'hC3;
  endfunction
  function automatic logic [7:0] xp_val(input logic [15:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  initial begin
    main_rdata = '0; scr_rdata = '0; csr_rdata = '0; x_rdata = '0;
  end

  always @(posedge clk) begin
    if (main_en) begin
      if (main_we) main_m[int'(mem_addr)] = mem_wdata;
      else main_rdata <= main_m.exists(int'(mem_addr)) ? main_m[int'(mem_addr)] : 8'h00;
    end
    if (scr_en) begin
      if (scr_we) scr_m[int'(mem_addr)] = mem_wdata;
      else scr_rdata <= scr_m.exists(int'(mem_addr)) ? scr_m[int'(mem_addr)] : 8'h00;
    end
    if (csr_sel) begin
      if (csr_we) csr_m[int'(mem_addr)] = mem_wdata;
      else csr_rdata <= csr_m.exists(int'(mem_addr)) ? csr_m[int'(mem_addr)] : csr_dflt(mem_addr);
    end
    if (xp_rd) x_rdata <= xp_val(mem_addr);
    if (xd_wr) xd_m[int'(mem_addr)] = mem_wdata;
    if (xd_rd) x_rdata <= xd_m.exists(int'(mem_addr)) ? xd_m[int'(mem_addr)] : 8'h00;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  // Snapshot of the strobe outputs in the request cycle.
  logic [8:0] st;   // {main_en,main_we,scr_en,scr_we,csr_sel,csr_we,xp_rd,xd_rd,xd_wr}
  logic       st_err;
  logic [7:0] rd_back;

  task automatic op(input logic [15:0] a, input bit f, input bit r, input bit w,
                    input logic [7:0] wd);
    cpu_addr = a; cpu_fetch = f; cpu_rd = r; cpu_wr = w; cpu_wdata = wd;
    #1;
    st     = {main_en, main_we, scr_en, scr_we, csr_sel, csr_we, xp_rd, xd_rd, xd_wr};
    st_err = dec_err;
    chk(($countones({main_en, scr_en, csr_sel, xp_rd, xd_rd | xd_wr}) <= 1),
        "R10", "targets enabled", $countones(st), 1);
    @(negedge clk);
    rd_back = cpu_rdata;
    cpu_fetch = 0; cpu_rd = 0; cpu_wr = 0;
  endtask

  localparam logic [8:0] S_MAIN_R = 9'b100000000;
  localparam logic [8:0] S_MAIN_W = 9'b110000000;
  localparam logic [8:0] S_SCR_R  = 9'b001000000;
  localparam logic [8:0] S_SCR_W  = 9'b001100000;
  localparam logic [8:0] S_CSR_R  = 9'b000010000;
  localparam logic [8:0] S_CSR_W  = 9'b000011000;
  localparam logic [8:0] S_XP     = 9'b000000100;
  localparam logic [8:0] S_XD_R   = 9'b000000010;
  localparam logic [8:0] S_XD_W   = 9'b000000001;
  localparam logic [8:0] S_IDLE   = 9'b000000000;

  task automatic t_reset;
    chk(cpu_rdata == 8'h00, "R11", "rdata in reset", cpu_rdata, 0);
    chk({main_en, main_we, scr_en, scr_we, csr_sel, csr_we, xp_rd, xd_rd, xd_wr, dec_err} == 10'b0,
        "R11", "strobes in reset",
        {main_en, main_we, scr_en, scr_we, csr_sel, csr_we, xp_rd, xd_rd, xd_wr, dec_err}, 0);
  endtask

  task automatic t_main_unified;
    op(16'h0123, 0, 0, 1, 8'hA5);
    chk(st == S_MAIN_W, "R2", "write strobes 0x0123", st, S_MAIN_W);
    op(16'h0123, 1, 0, 0, 8'h00);
    chk(st == S_MAIN_R, "R1", "fetch strobes 0x0123", st, S_MAIN_R);
    chk(rd_back == 8'hA5, "R2", "fetch after write", rd_back, 8'hA5);
    op(16'h0123, 0, 1, 0, 8'h00);
    chk(st == S_MAIN_R, "R1", "data read strobes", st, S_MAIN_R);
    chk(rd_back == 8'hA5, "R1", "data read value", rd_back, 8'hA5);
    op(16'h1FFF, 0, 0, 1, 8'h3C);
    op(16'h1FFF, 1, 0, 0, 8'h00);
    chk(st == S_MAIN_R && rd_back == 8'h3C, "R2", "top byte fetch", rd_back, 8'h3C);
  endtask

  task automatic t_scratch;
    op(16'hE010, 0, 0, 1, 8'h77);
    chk(st == S_SCR_W, "R3", "scratch write strobes", st, S_SCR_W);
    op(16'hE010, 0, 1, 0, 8'h00);
    chk(st == S_SCR_R && rd_back == 8'h77, "R3", "scratch read", rd_back, 8'h77);
    op(16'hE1FF, 0, 0, 1, 8'h19);
    op(16'hE1FF, 0, 1, 0, 8'h00);
    chk(rd_back == 8'h19, "R3", "scratch top byte", rd_back, 8'h19);
  endtask

  task automatic t_fetch_high;
    op(16'hE010, 1, 0, 0, 8'h00);
    chk(st == S_XP, "R4", "fetch in scratch strobes", st, S_XP);
    chk(rd_back == xp_val(16'hE010), "R4", "fetch in scratch data", rd_back, xp_val(16'hE010));
    op(16'h2000, 1, 0, 0, 8'h00);
    chk(st == S_XP && rd_back == xp_val(16'h2000), "R4", "fetch at 0x2000",
        rd_back, xp_val(16'h2000));
    op(16'hFFF0, 1, 0, 0, 8'h00);
    chk(st == S_XP, "R4", "fetch in register window", st, S_XP);
  endtask

  task automatic t_csr;
    op(16'hE200, 0, 1, 0, 8'h00);
    chk(st == S_CSR_R && rd_back == csr_dflt(16'hE200), "R5", "register read",
        rd_back, csr_dflt(16'hE200));
    op(16'hFFFF, 0, 0, 1, 8'h81);
    chk(st == S_CSR_W, "R5", "register write strobes", st, S_CSR_W);
    op(16'hFFFF, 0, 1, 0, 8'h00);
    chk(rd_back == 8'h81, "R5", "register readback", rd_back, 8'h81);
  endtask

  task automatic t_ext_data;
    op(16'h2000, 0, 0, 1, 8'h42);
    chk(st == S_XD_W, "R6", "ext data write", st, S_XD_W);
    op(16'h2000, 0, 1, 0, 8'h00);
    chk(st == S_XD_R && rd_back == 8'h42, "R6", "ext data read", rd_back, 8'h42);
    op(16'hDFFF, 0, 1, 0, 8'h00);
    chk(st == S_XD_R, "R6", "ext data top strobes", st, S_XD_R);
  endtask

  task automatic t_conflict;
    op(16'h0123, 1, 1, 0, 8'h00);
    chk(st_err == 1'b1 && st == S_MAIN_R, "R7", "fetch+read low", {st_err, st}, {1'b1, S_MAIN_R});
    chk(rd_back == 8'hA5, "R7", "fetch+read low data", rd_back, 8'hA5);
    op(16'hE010, 1, 1, 0, 8'h00);
    chk(st_err == 1'b1 && st == S_XP, "R7", "fetch+read scratch", {st_err, st}, {1'b1, S_XP});
    op(16'h4000, 1, 0, 1, 8'h00);
    chk(st_err == 1'b0, "R7", "no error on fetch+write", st_err, 0);
  endtask

  task automatic t_write_drop;
    op(16'h0123, 1, 0, 1, 8'hEE);
    chk(st == S_MAIN_R, "R8", "fetch+write low strobes", st, S_MAIN_R);
    op(16'h0123, 0, 1, 0, 8'h00);
    chk(rd_back == 8'hA5, "R8", "low byte unchanged", rd_back, 8'hA5);
    op(16'hE010, 1, 0, 1, 8'hEE);
    chk(st == S_XP, "R8", "fetch+write scratch strobes", st, S_XP);
    op(16'hE010, 0, 1, 0, 8'h00);
    chk(rd_back == 8'h77, "R8", "scratch byte unchanged", rd_back, 8'h77);
    op(16'hFFFF, 1, 0, 1, 8'hEE);
    chk(st == S_XP, "R8", "fetch+write register strobes", st, S_XP);
    op(16'hFFFF, 0, 1, 0, 8'h00);
    chk(rd_back == 8'h81, "R8", "register byte unchanged", rd_back, 8'h81);
    op(16'hE1FF, 0, 1, 1, 8'hEE);
    chk(st == S_SCR_R && rd_back == 8'h19, "R8", "read+write scratch", rd_back, 8'h19);
  endtask

  task automatic t_latency;
    op(16'h0123, 0, 1, 0, 8'h00);
    chk(rd_back == 8'hA5, "R9", "main one cycle", rd_back, 8'hA5);
    op(16'h0000, 0, 0, 0, 8'h00);
    chk(st == S_IDLE && rd_back == 8'h00, "R9", "idle after read", rd_back, 0);
    op(16'h3000, 0, 0, 1, 8'h99);
    chk(rd_back == 8'h00, "R9", "write returns zero", rd_back, 0);
  endtask

  initial begin
    rst_n = 0; cpu_addr = '0; cpu_fetch = 0; cpu_rd = 0; cpu_wr = 0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_main_unified();
    t_scratch();
    t_fetch_high();
    t_csr();
    t_ext_data();
    t_conflict();
    t_write_drop();
    t_latency();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule